// File: doc/BRIEF.md
# Event-Controlled Down-Counting Bit Timer

This block is a 16-bit bit-period timer that drives a companion shift register. When it starts, the counter loads a reload value and counts down toward zero. Each time the count runs out, the counter reloads, the timer output toggles, and the block advances one bit period. Some of those bit periods are data periods. For each data period the block emits a one-cycle shift strobe. After the configured number of data periods it also emits a store strobe and sets a sticky status flag.

Four configuration fields each pick the source of one control action:
- **Start:** free-running, a trigger rising edge, a pin rising edge, or a shifter request level.
- **Count:** every clock, or only on trigger or pin edges.
- **Restart:** none, trigger edges, or a pin rising edge.
- **Stop:** never, after a completed transfer, a trigger falling edge, or a pin falling edge.

An optional leading bit period with no shift and an optional trailing bit period with no shift can surround the data periods. Because the output toggles once per bit period, it can serve as a bit clock or as a select/PWM-style waveform. The register interface and pin multiplexing are outside the block.

Top module: `evt_timer`

## Requirements
- R1: Sync reset (`rst`=1) gives tmr_active=0, tmr_out=0, shift_stb=0, store_stb=0 and tmr_flag=0.
- R2: `cfg_en_src` selects the start condition while idle: 0 = start at once, 1 = rising edge of trig_in, 2 = rising edge of pin_in, 3 = shifter_req high. The timer becomes active at the clock edge that sees the condition. While active it ignores start conditions. While idle it ignores conditions other than the selected one.
- R3: A start loads the counter with `cfg_compare` (C). Each count tick decrements it. A tick with the count at zero is an expiry: the counter reloads C. With counting on every clock, one bit period lasts C+1 cycles.
- R4: `cfg_dec_src` selects the count tick: 0 = every clock, 1 = rising edge of trig_in, 2 = rising edge of pin_in, 3 = either edge of pin_in. A level held for many cycles gives exactly one tick per edge.
- R5: Each expiry in a data period drives shift_stb high for one cycle. A transfer has `cfg_beats` data periods, and a value of 0 acts as 1.
- R6: store_stb rises in the same cycle as the last shift_stb of a transfer. At that point tmr_flag sets. tmr_flag stays set until a cycle with flag_clr=1 and no new store.
- R7: With `cfg_start_bit`=1, one bit period without a shift strobe comes before the data periods.
- R8: With `cfg_stop_bit`=1, one bit period without a shift strobe follows the data periods, before the transfer ends.
- R9: tmr_out goes to 0 on start and toggles at every expiry while active. It is 0 whenever tmr_active is 0.
- R10: `cfg_rst_src` selects a restart while active: 0 = none, 1 = rising edge of trig_in, 2 = rising edge of pin_in, 3 = either edge of trig_in. A restart reloads C, clears tmr_out and begins the transfer again from its first period.
- R11: `cfg_dis_src` selects how the timer stops: 0 = never, so the transfer repeats back to back; 1 = at the end of a transfer; 2 = falling edge of trig_in; 3 = falling edge of pin_in. An edge stop takes effect at the clock edge that sees the edge, and it takes priority over a restart or an expiry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_src | input | 2 | Start source select |
| cfg_dec_src | input | 2 | Count tick source select |
| cfg_rst_src | input | 2 | Restart source select |
| cfg_dis_src | input | 2 | Stop source select |
| cfg_start_bit | input | 1 | Insert leading bit period |
| cfg_stop_bit | input | 1 | Insert trailing bit period |
| cfg_compare | input | CNT_W | Reload value |
| cfg_beats | input | BEAT_W | Data periods per transfer |
| trig_in | input | 1 | Trigger input |
| pin_in | input | 1 | Pin input |
| shifter_req | input | 1 | Shifter condition level |
| flag_clr | input | 1 | Clears the status flag |
| tmr_out | output | 1 | Timer output waveform |
| shift_stb | output | 1 | One-cycle shift strobe |
| store_stb | output | 1 | One-cycle store strobe |
| tmr_flag | output | 1 | Sticky transfer-done flag |
| tmr_active | output | 1 | Timer is running |

## Verification
The bench sweeps small reload values (including 0), one to three data periods and every combination of start and stop periods. On each cycle it compares every strobe and the output against positions computed arithmetically. That sweep catches an off-by-one period, which would move every strobe, and a start or stop period placed on the wrong side of the data, which would shift the store strobe. Edge-counting tests hold trig_in high for several cycles; a level-sensitive tick would run the count out early. A restart partway through a period must push the strobe to a later cycle, and a trigger falling edge must stop the timer mid-period with the output low. A free-running repeat test exposes a design that fails to reload after the final period.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    EN_AT_ONCE    = 2'd0,
    EN_TRIG_RISE  = 2'd1,
    EN_PIN_RISE   = 2'd2,
    EN_SHIFTER    = 2'd3
  } en_src_e;

  typedef enum logic [1:0] {
    TICK_CLOCK     = 2'd0,
    TICK_TRIG_RISE = 2'd1,
    TICK_PIN_RISE  = 2'd2,
    TICK_PIN_ANY   = 2'd3
  } tick_src_e;

  typedef enum logic [1:0] {
    RS_NONE       = 2'd0,
    RS_TRIG_RISE  = 2'd1,
    RS_PIN_RISE   = 2'd2,
    RS_TRIG_ANY   = 2'd3
  } rs_src_e;

  typedef enum logic [1:0] {
    STOP_NEVER     = 2'd0,
    STOP_AT_END    = 2'd1,
    STOP_TRIG_FALL = 2'd2,
    STOP_PIN_FALL  = 2'd3
  } stop_src_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_DATA  = 2'd2,
    PH_TRAIL = 2'd3
  } phase_e;

  typedef struct packed {
    logic trig_rise;
    logic trig_fall;
    logic pin_rise;
    logic pin_fall;
  } edges_t;

endpackage

// File: rtl/evt_timer_edges.sv
module evt_timer_edges
  import evt_timer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   trig_in,
  input  logic   pin_in,
  output edges_t edges
);

  logic trig_q;
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      trig_q <= trig_in;
      pin_q  <= pin_in;
    end
  end

  always_comb begin
    edges.trig_rise = trig_in & ~trig_q;
    edges.trig_fall = ~trig_in & trig_q;
    edges.pin_rise  = pin_in & ~pin_q;
    edges.pin_fall  = ~pin_in & pin_q;
  end

endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  assign expire = tick && (cnt == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ZERO;
    end else if (load || expire) begin
      cnt <= reload;
    end else if (tick) begin
      cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/evt_timer_seq.sv
module evt_timer_seq
  import evt_timer_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              restart_evt,
  input  logic              stop_evt,
  input  logic              stop_at_end,
  input  logic              expire,
  input  logic              lead_en,
  input  logic              trail_en,
  input  logic [BEAT_W-1:0] beats,
  input  logic              flag_clr,
  output logic              load_req,
  output logic              active,
  output logic              tmr_out,
  output logic              shift_stb,
  output logic              store_stb,
  output logic              tmr_flag
);

  localparam logic [BEAT_W-1:0] BEAT_ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

  phase_e            phase_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beats_eff;
  logic              last_beat;
  phase_e            first_phase;
  logic              run_expire;
  logic              store_now;

  assign beats_eff   = (beats == '0) ? BEAT_ONE : beats;
  assign last_beat   = (beat_q + BEAT_ONE) >= beats_eff;
  assign first_phase = lead_en ? PH_LEAD : PH_DATA;
  assign active      = (phase_q != PH_IDLE);
  assign run_expire  = active && !stop_evt && !restart_evt && expire;
  assign store_now   = run_expire && (phase_q == PH_DATA) && last_beat;
  assign load_req    = (!active && start_evt) || (active && !stop_evt && restart_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      beat_q    <= '0;
      tmr_out   <= 1'b0;
      shift_stb <= 1'b0;
      store_stb <= 1'b0;
      tmr_flag  <= 1'b0;
    end else begin
      shift_stb <= 1'b0;
      store_stb <= 1'b0;
      if (store_now) begin
        tmr_flag <= 1'b1;
      end else if (flag_clr) begin
        tmr_flag <= 1'b0;
      end
      if (!active) begin
        if (start_evt) begin
          phase_q <= first_phase;
          beat_q  <= '0;
          tmr_out <= 1'b0;
        end
      end else if (stop_evt) begin
        phase_q <= PH_IDLE;
        tmr_out <= 1'b0;
      end else if (restart_evt) begin
        phase_q <= first_phase;
        beat_q  <= '0;
        tmr_out <= 1'b0;
      end else if (expire) begin
        tmr_out <= ~tmr_out;
        unique case (phase_q)
          PH_LEAD: begin
            phase_q <= PH_DATA;
            beat_q  <= '0;
          end
          PH_DATA: begin
            shift_stb <= 1'b1;
            if (last_beat) begin
              store_stb <= 1'b1;
              if (trail_en) begin
                phase_q <= PH_TRAIL;
              end else if (stop_at_end) begin
                phase_q <= PH_IDLE;
                tmr_out <= 1'b0;
              end else begin
                phase_q <= first_phase;
                beat_q  <= '0;
              end
            end else begin
              beat_q <= beat_q + BEAT_ONE;
            end
          end
          PH_TRAIL: begin
            if (stop_at_end) begin
              phase_q <= PH_IDLE;
              tmr_out <= 1'b0;
            end else begin
              phase_q <= first_phase;
              beat_q  <= '0;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_en_src,
  input  logic [1:0]        cfg_dec_src,
  input  logic [1:0]        cfg_rst_src,
  input  logic [1:0]        cfg_dis_src,
  input  logic              cfg_start_bit,
  input  logic              cfg_stop_bit,
  input  logic [CNT_W-1:0]  cfg_compare,
  input  logic [BEAT_W-1:0] cfg_beats,
  input  logic              trig_in,
  input  logic              pin_in,
  input  logic              shifter_req,
  input  logic              flag_clr,
  output logic              tmr_out,
  output logic              shift_stb,
  output logic              store_stb,
  output logic              tmr_flag,
  output logic              tmr_active
);

  edges_t           edges;
  logic             start_evt;
  logic             tick_raw;
  logic             restart_evt;
  logic             stop_evt;
  logic             stop_at_end;
  logic             load_req;
  logic             expire;
  logic             active;
  logic [CNT_W-1:0] cnt_q;

  evt_timer_edges u_edges (
    .clk     (clk),
    .rst     (rst),
    .trig_in (trig_in),
    .pin_in  (pin_in),
    .edges   (edges)
  );

  always_comb begin
    unique case (en_src_e'(cfg_en_src))
      EN_AT_ONCE:   start_evt = 1'b1;
      EN_TRIG_RISE: start_evt = edges.trig_rise;
      EN_PIN_RISE:  start_evt = edges.pin_rise;
      default:      start_evt = shifter_req;
    endcase
    unique case (tick_src_e'(cfg_dec_src))
      TICK_CLOCK:     tick_raw = 1'b1;
      TICK_TRIG_RISE: tick_raw = edges.trig_rise;
      TICK_PIN_RISE:  tick_raw = edges.pin_rise;
      default:        tick_raw = edges.pin_rise | edges.pin_fall;
    endcase
    unique case (rs_src_e'(cfg_rst_src))
      RS_NONE:      restart_evt = 1'b0;
      RS_TRIG_RISE: restart_evt = edges.trig_rise;
      RS_PIN_RISE:  restart_evt = edges.pin_rise;
      default:      restart_evt = edges.trig_rise | edges.trig_fall;
    endcase
    unique case (stop_src_e'(cfg_dis_src))
      STOP_NEVER:     stop_evt = 1'b0;
      STOP_AT_END:    stop_evt = 1'b0;
      STOP_TRIG_FALL: stop_evt = edges.trig_fall;
      default:        stop_evt = edges.pin_fall;
    endcase
  end

  assign stop_at_end = (stop_src_e'(cfg_dis_src) == STOP_AT_END);

  evt_timer_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk    (clk),
    .rst    (rst),
    .load   (load_req),
    .tick   (tick_raw & active),
    .reload (cfg_compare),
    .cnt    (cnt_q),
    .expire (expire)
  );

  evt_timer_seq #(
    .BEAT_W (BEAT_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_evt   (start_evt),
    .restart_evt (restart_evt),
    .stop_evt    (stop_evt),
    .stop_at_end (stop_at_end),
    .expire      (expire),
    .lead_en     (cfg_start_bit),
    .trail_en    (cfg_stop_bit),
    .beats       (cfg_beats),
    .flag_clr    (flag_clr),
    .load_req    (load_req),
    .active      (active),
    .tmr_out     (tmr_out),
    .shift_stb   (shift_stb),
    .store_stb   (store_stb),
    .tmr_flag    (tmr_flag)
  );

  assign tmr_active = active;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cfg_compare,
  input logic [CNT_W-1:0] cnt_q,
  input logic             tmr_out,
  input logic             shift_stb,
  input logic             store_stb,
  input logic             tmr_flag,
  input logic             tmr_active
);

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!tmr_active && !shift_stb && !store_stb && !tmr_flag));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    tmr_active |-> (cnt_q <= cfg_compare));

  p_shift_from_active_r5: assert property (@(posedge clk) disable iff (rst)
    shift_stb |-> $past(tmr_active));

  p_store_with_shift_r6: assert property (@(posedge clk) disable iff (rst)
    store_stb |-> shift_stb);

  p_flag_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_flag) |-> store_stb);

  p_idle_out_low_r9: assert property (@(posedge clk) disable iff (rst)
    !tmr_active |-> !tmr_out);

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_compare (cfg_compare),
  .cnt_q       (cnt_q),
  .tmr_out     (tmr_out),
  .shift_stb   (shift_stb),
  .store_stb   (store_stb),
  .tmr_flag    (tmr_flag),
  .tmr_active  (tmr_active)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;

  localparam int CNT_W  = 16;
  localparam int BEAT_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cfg_en_src = 2'd1;
  logic [1:0]        cfg_dec_src = 2'd0;
  logic [1:0]        cfg_rst_src = 2'd0;
  logic [1:0]        cfg_dis_src = 2'd1;
  logic              cfg_start_bit = 1'b0;
  logic              cfg_stop_bit = 1'b0;
  logic [CNT_W-1:0]  cfg_compare = '0;
  logic [BEAT_W-1:0] cfg_beats = 8'd1;
  logic              trig_in = 1'b0;
  logic              pin_in = 1'b0;
  logic              shifter_req = 1'b0;
  logic              flag_clr = 1'b0;
  logic              tmr_out;
  logic              shift_stb;
  logic              store_stb;
  logic              tmr_flag;
  logic              tmr_active;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  evt_timer #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_evt_timer (
    .clk(clk), .rst(rst),
    .cfg_en_src(cfg_en_src), .cfg_dec_src(cfg_dec_src),
    .cfg_rst_src(cfg_rst_src), .cfg_dis_src(cfg_dis_src),
    .cfg_start_bit(cfg_start_bit), .cfg_stop_bit(cfg_stop_bit),
    .cfg_compare(cfg_compare), .cfg_beats(cfg_beats),
    .trig_in(trig_in), .pin_in(pin_in), .shifter_req(shifter_req),
    .flag_clr(flag_clr),
    .tmr_out(tmr_out), .shift_stb(shift_stb), .store_stb(store_stb),
    .tmr_flag(tmr_flag), .tmr_active(tmr_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    trig_in = 1'b0;
    pin_in = 1'b0;
    shifter_req = 1'b0;
    flag_clr = 1'b0;
    step();
    step();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    step();
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // Sweep: trigger-rise start, clock ticks, stop at end of transfer
  task automatic run_xfer(input int c, input int b, input int s, input int p);
    int per;
    int tot;
    cfg_en_src = 2'd1; cfg_dec_src = 2'd0; cfg_rst_src = 2'd0; cfg_dis_src = 2'd1;
    cfg_compare = CNT_W'(c); cfg_beats = BEAT_W'(b);
    cfg_start_bit = s[0]; cfg_stop_bit = p[0];
    per = c + 1;
    tot = b + s + p;
    @(negedge clk);
    trig_in = 1'b1;
    step();
    chk("R2 start on trig rise", tmr_active, 1);
    chk("R9 out low at start", tmr_out, 0);
    @(negedge clk);
    trig_in = 1'b0;
    for (int j = 1; j <= per * tot + 2; j++) begin
      int m;
      int at_exp;
      int act_e;
      step();
      m = j / per;
      at_exp = (j % per == 0) ? 1 : 0;
      act_e = (m < tot) ? 1 : 0;
      chk("R3/R11 active window", tmr_active, act_e);
      chk("R5/R7 shift position", shift_stb,
          (at_exp == 1 && m >= s + 1 && m <= s + b) ? 1 : 0);
      chk("R6/R8 store position", store_stb, (at_exp == 1 && m == s + b) ? 1 : 0);
      chk("R9 output toggle", tmr_out, (act_e == 1) ? (m % 2) : 0);
    end
    chk("R6 flag held", tmr_flag, 1);
    clear_flag();
    #1;
    chk("R6 flag cleared", tmr_flag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int nshift;
    do_reset();
    #1;
    chk("R1 active", tmr_active, 0);
    chk("R1 out", tmr_out, 0);
    chk("R1 shift", shift_stb, 0);
    chk("R1 store", store_stb, 0);
    chk("R1 flag", tmr_flag, 0);

    // R3 R5 R6 R7 R8 R9 sweep
    for (int c = 0; c < 4; c++)
      for (int b = 1; b <= 3; b++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 2; p++)
            run_xfer(c, b, s, p);

    // R5: beats = 0 acts as one data period
    cfg_beats = 8'd0; cfg_compare = 16'd1; cfg_start_bit = 0; cfg_stop_bit = 0;
    @(negedge clk); trig_in = 1'b1; step(); @(negedge clk); trig_in = 1'b0;
    nshift = 0;
    for (int j = 1; j <= 6; j++) begin step(); nshift += shift_stb; end
    chk("R5 zero beats acts as one", nshift, 1);
    chk("R5 zero beats done", tmr_active, 0);
    clear_flag();

    // R2: ignored start sources
    do_reset();
    cfg_en_src = 2'd2; cfg_compare = 16'd0; cfg_beats = 8'd1; cfg_dis_src = 2'd1;
    @(negedge clk); trig_in = 1'b1; shifter_req = 1'b1; step();
    chk("R2 trig ignored for pin source", tmr_active, 0);
    @(negedge clk); trig_in = 1'b0; shifter_req = 1'b0;
    cfg_en_src = 2'd3;
    for (int j = 0; j < 4; j++) begin
      step();
      chk("R2 shifter low stays idle", tmr_active, 0);
    end
    @(negedge clk); shifter_req = 1'b1; step();
    chk("R2 shifter start", tmr_active, 1);
    @(negedge clk); shifter_req = 1'b0; step();
    chk("R2 shifter shift", shift_stb, 1);
    chk("R2 shifter transfer ends", tmr_active, 0);

    // R2: start at once
    do_reset();
    cfg_en_src = 2'd0; cfg_compare = 16'd3; cfg_dis_src = 2'd1;
    step();
    chk("R2 at-once start", tmr_active, 1);

    // R4: count on trigger rising edges, level held several cycles
    do_reset();
    cfg_en_src = 2'd2; cfg_dec_src = 2'd1; cfg_compare = 16'd2; cfg_beats = 8'd1;
    cfg_dis_src = 2'd1; cfg_rst_src = 2'd0;
    @(negedge clk); pin_in = 1'b1; step(); @(negedge clk); pin_in = 1'b0;
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk); trig_in = 1'b1;
      step();
      chk("R4 shift only on third edge", shift_stb, (e == 3) ? 1 : 0);
      step();
      chk("R4 held level gives no tick", shift_stb, 0);
      @(negedge clk); trig_in = 1'b0;
      step();
      chk("R4 falling edge gives no tick", shift_stb, 0);
    end
    chk("R4 transfer done after three edges", tmr_active, 0);

    // R4: either edge of pin
    do_reset();
    cfg_en_src = 2'd1; cfg_dec_src = 2'd3; cfg_compare = 16'd1;
    @(negedge clk); trig_in = 1'b1; step(); @(negedge clk); trig_in = 1'b0;
    @(negedge clk); pin_in = 1'b1; step();
    chk("R4 pin rise tick no expiry", shift_stb, 0);
    @(negedge clk); pin_in = 1'b0; step();
    chk("R4 pin fall tick expires", shift_stb, 1);

    // R10: restart by pin rise
    do_reset();
    cfg_en_src = 2'd1; cfg_dec_src = 2'd0; cfg_rst_src = 2'd2; cfg_compare = 16'd5;
    cfg_beats = 8'd1; cfg_dis_src = 2'd1;
    @(negedge clk); trig_in = 1'b1; step(); @(negedge clk); trig_in = 1'b0;
    for (int j = 1; j <= 11; j++) begin
      @(negedge clk); pin_in = (j == 3) ? 1'b1 : 1'b0;
      step();
      chk("R10 restart moves shift", shift_stb, (j == 9) ? 1 : 0);
    end

    // R11: trigger falling edge stops mid-period
    do_reset();
    cfg_en_src = 2'd2; cfg_dec_src = 2'd0; cfg_rst_src = 2'd0; cfg_dis_src = 2'd2;
    cfg_compare = 16'd3; cfg_beats = 8'd4;
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); pin_in = 1'b1; step(); @(negedge clk); pin_in = 1'b0;
    for (int j = 1; j <= 5; j++) step();
    chk("R11 running before stop", tmr_active, 1);
    chk("R9 out high in second period", tmr_out, 1);
    @(negedge clk); trig_in = 1'b0; step();
    chk("R11 edge stop", tmr_active, 0);
    chk("R11 edge stop output low", tmr_out, 0);
    nshift = 0;
    for (int j = 0; j < 10; j++) begin step(); nshift += shift_stb; end
    chk("R11 no shifts after stop", nshift, 0);

    // R11: never stop, transfers repeat
    do_reset();
    cfg_en_src = 2'd1; cfg_dis_src = 2'd0; cfg_compare = 16'd1; cfg_beats = 8'd2;
    @(negedge clk); trig_in = 1'b1; step(); @(negedge clk); trig_in = 1'b0;
    for (int j = 1; j <= 12; j++) begin
      step();
      chk("R11 repeating store", store_stb, (j % 4 == 0) ? 1 : 0);
      chk("R11 stays active", tmr_active, 1);
    end

    do_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule